// File: doc/BRIEF.md
# ALU Status Flag Generator

This block produces the status and control flag word that sits beside an integer ALU. Each cycle it looks at the two operands, the carry-in, the operation class, an operand-size select and the result the ALU produced. From these it forms carry, parity, auxiliary carry, zero, sign and overflow. When the ALU write enable is high, those six status bits are captured into a 16-bit flag register.

The same register holds three control bits: single-step trap, interrupt enable and string direction. These bits change only through a separate control write port, never through an ALU result. Reserved bit positions always read the same fixed values. The operand-size select picks between 8-bit and 16-bit arithmetic. Parity always looks at the low byte of the result, whatever the size.

Top module: `alu_flag_unit`

## Requirements
- R1: After reset the flag word reads 16'h0002: all status and control bits are zero and the reserved bits hold their fixed values.
- R2: The carry bit (bit 0) is set for an add when operand_a + operand_b + carry_in carries out of the top bit of the selected width. For a subtract it is set when operand_a - operand_b - carry_in needs a borrow, that is when a < b + carry_in, compared unsigned over the selected width.
- R3: The parity bit (bit 2) is set when result[7:0] holds an even number of ones, in both sizes.
- R4: The auxiliary carry bit (bit 4) is set for an add on a carry out of bit 3 (a[3:0] + b[3:0] + carry_in > 15). For a subtract it is set on a borrow from bit 4 (a[3:0] < b[3:0] + carry_in).
- R5: The zero bit (bit 6) is set when the result is zero over the selected width, so result bits above bit 7 are ignored in 8-bit mode. The sign bit (bit 7) equals the result's top bit for the selected width (bit 7 or bit 15).
- R6: The overflow bit (bit 11) is set for an add when both operands share a sign and the result's sign differs from it. For a subtract it is set when the operands' signs differ and the result's sign differs from operand_a's sign. Signs are taken at the top bit of the selected width.
- R7: op_class encoding: 2'b00 add, 2'b01 subtract, 2'b10 and 2'b11 logic. For logic classes, carry, auxiliary carry and overflow are written as zero.
- R8: The status bits change only on a clock edge with flag_we high. With flag_we low they hold whatever the inputs do.
- R9: A clock edge with ctrl_we high loads ctrl_wdata[0] into trap (bit 8), ctrl_wdata[1] into interrupt (bit 9) and ctrl_wdata[2] into direction (bit 10). ALU writes never change these bits, and control writes never change status bits.
- R10: Reserved bits read fixed values at all times: bit 1 reads one, and bits 3, 5, 12, 13, 14 and 15 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| operand_a | input | 16 | First ALU operand |
| operand_b | input | 16 | Second ALU operand |
| alu_result | input | 16 | Result produced by the ALU |
| carry_in | input | 1 | Carry or borrow into the operation |
| op_class | input | 2 | 00 add, 01 subtract, 1x logic |
| size_wide | input | 1 | 0 selects 8-bit, 1 selects 16-bit operands |
| flag_we | input | 1 | Capture status flags this edge |
| ctrl_we | input | 1 | Load the control bits this edge |
| ctrl_wdata | input | 3 | {direction, interrupt, trap} write data |
| flags_out | output | 16 | Registered flag word |

## Verification
The bench targets the points where the operand width matters. An 8-bit add whose result carries junk in the upper byte must still report zero; a design that checks all 16 bits clears zero there. An 8-bit overflow must come from bit 7, not bit 15. Subtracts with a borrow-in catch a carry or auxiliary-carry formula that ignores carry_in or inverts the borrow sense. Logic operations on operands that would overflow show whether carry and overflow are truly forced low. Writes interleaved with held cycles and control loads expose status bits that drift without flag_we, and control bits that an ALU write clobbers.

// File: rtl/flagu_pkg.sv
package flagu_pkg;
  typedef enum logic [1:0] {
    OPC_ADD    = 2'b00,
    OPC_SUB    = 2'b01,
    OPC_LOGIC  = 2'b10,
    OPC_LOGICX = 2'b11
  } op_class_e;

  localparam int CF_POS = 0;
  localparam int PF_POS = 2;
  localparam int AF_POS = 4;
  localparam int ZF_POS = 6;
  localparam int SF_POS = 7;
  localparam int TF_POS = 8;
  localparam int IF_POS = 9;
  localparam int DF_POS = 10;
  localparam int OF_POS = 11;

  localparam int FLAG_W = 16;
  localparam logic [FLAG_W-1:0] RESV_VALUE = 16'h0002;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zer;
    logic aux;
    logic par;
    logic cry;
  } status_t;

  typedef struct packed {
    logic dir;
    logic intr;
    logic trap;
  } ctrl_t;
endpackage

// File: rtl/flag_calc.sv
module flag_calc
  import flagu_pkg::*;
#(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic [WIDE_W-1:0] a,
  input  logic [WIDE_W-1:0] b,
  input  logic [WIDE_W-1:0] res,
  input  logic              cin,
  input  op_class_e         cls,
  input  logic              wide,
  output status_t           st
);
  localparam int NIB_W = 4;

  function automatic logic even_ones(input logic [7:0] v);
    return ~(^v);
  endfunction

  function automatic logic add_cout(input logic [WIDE_W-1:0] x, input logic [WIDE_W-1:0] y,
                                    input logic c, input int w);
    logic [WIDE_W:0] s;
    s = {1'b0, x} + {1'b0, y} + {{WIDE_W{1'b0}}, c};
    return s[w];
  endfunction

  function automatic logic sub_bout(input logic [WIDE_W-1:0] x, input logic [WIDE_W-1:0] y,
                                    input logic c, input int w);
    logic [WIDE_W:0] d;
    d = {1'b0, x} - {1'b0, y} - {{WIDE_W{1'b0}}, c};
    return d[w];
  endfunction

  logic [WIDE_W-1:0] a_m, b_m, r_m;
  logic              carry_add, borrow_sub, half_add, half_sub;
  logic              a_msb, b_msb, r_msb, res_zero;
  logic              is_add, is_sub;
  logic [NIB_W:0]    nib_sum, nib_dif;

  always_comb begin
    if (wide) begin
      a_m = a;
      b_m = b;
      r_m = res;
    end else begin
      a_m = {{(WIDE_W-NARROW_W){1'b0}}, a[NARROW_W-1:0]};
      b_m = {{(WIDE_W-NARROW_W){1'b0}}, b[NARROW_W-1:0]};
      r_m = {{(WIDE_W-NARROW_W){1'b0}}, res[NARROW_W-1:0]};
    end
    carry_add  = add_cout(a_m, b_m, cin, wide ? WIDE_W : NARROW_W);
    borrow_sub = sub_bout(a_m, b_m, cin, wide ? WIDE_W : NARROW_W);
    nib_sum    = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    nib_dif    = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]} - {{NIB_W{1'b0}}, cin};
    half_add   = nib_sum[NIB_W];
    half_sub   = nib_dif[NIB_W];
    a_msb      = wide ? a[WIDE_W-1]   : a[NARROW_W-1];
    b_msb      = wide ? b[WIDE_W-1]   : b[NARROW_W-1];
    r_msb      = wide ? res[WIDE_W-1] : res[NARROW_W-1];
    res_zero   = (r_m == '0);
    is_add     = (cls == OPC_ADD);
    is_sub     = (cls == OPC_SUB);

    st.par = even_ones(res[7:0]);
    st.zer = res_zero;
    st.sgn = r_msb;
    st.cry = is_add ? carry_add : (is_sub ? borrow_sub : 1'b0);
    st.aux = is_add ? half_add  : (is_sub ? half_sub   : 1'b0);
    st.ovf = is_add ? ((a_msb == b_msb) && (r_msb != a_msb)) :
             (is_sub ? ((a_msb != b_msb) && (r_msb != a_msb)) : 1'b0);
  end

  // R5: a zero result can never carry a set sign bit
  always_comb begin
    assert_zero_sign_R5: assert (!(st.zer && st.sgn));
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import flagu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  status_t           st_in,
  input  logic              st_we,
  input  ctrl_t             ctl_in,
  input  logic              ctl_we,
  output logic [FLAG_W-1:0] word
);
  status_t st_q;
  ctrl_t   ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      ctl_q <= '0;
    end else begin
      if (st_we)  st_q  <= st_in;
      if (ctl_we) ctl_q <= ctl_in;
    end
  end

  always_comb begin
    word         = RESV_VALUE;
    word[CF_POS] = st_q.cry;
    word[PF_POS] = st_q.par;
    word[AF_POS] = st_q.aux;
    word[ZF_POS] = st_q.zer;
    word[SF_POS] = st_q.sgn;
    word[OF_POS] = st_q.ovf;
    word[TF_POS] = ctl_q.trap;
    word[IF_POS] = ctl_q.intr;
    word[DF_POS] = ctl_q.dir;
  end

  assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !st_we |=> $stable({word[OF_POS], word[SF_POS], word[ZF_POS], word[AF_POS], word[PF_POS], word[CF_POS]}));

  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(word[DF_POS:TF_POS]));

  assert_ctrl_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (word[DF_POS:TF_POS] == $past(ctl_in)));
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import flagu_pkg::*;
#(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDE_W-1:0] operand_a,
  input  logic [WIDE_W-1:0] operand_b,
  input  logic [WIDE_W-1:0] alu_result,
  input  logic              carry_in,
  input  logic [1:0]        op_class,
  input  logic              size_wide,
  input  logic              flag_we,
  input  logic              ctrl_we,
  input  logic [2:0]        ctrl_wdata,
  output logic [15:0]       flags_out
);
  status_t   calc_st;
  ctrl_t     ctl_w;
  op_class_e cls;

  assign cls   = op_class_e'(op_class);
  assign ctl_w = '{dir: ctrl_wdata[2], intr: ctrl_wdata[1], trap: ctrl_wdata[0]};

  flag_calc #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) calc_i (
    .a(operand_a), .b(operand_b), .res(alu_result), .cin(carry_in),
    .cls(cls), .wide(size_wide), .st(calc_st)
  );

  flag_reg reg_i (
    .clk(clk), .rst_n(rst_n), .st_in(calc_st), .st_we(flag_we),
    .ctl_in(ctl_w), .ctl_we(ctrl_we), .word(flags_out)
  );

  assert_logic_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_class[1]) |=> (!flags_out[CF_POS] && !flags_out[AF_POS] && !flags_out[OF_POS]));

  assert_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_out[1] && !flags_out[3] && !flags_out[5] && (flags_out[15:12] == 4'h0)));

  assert_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (flags_out[PF_POS] == ~(^$past(alu_result[7:0]))));
endmodule

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] operand_a = '0, operand_b = '0, alu_result = '0;
  logic        carry_in = 1'b0, size_wide = 1'b0, flag_we = 1'b0, ctrl_we = 1'b0;
  logic [1:0]  op_class = '0;
  logic [2:0]  ctrl_wdata = '0;
  logic [15:0] flags_out;

  int total = 0;
  int bad = 0;
  logic [2:0]  shadow_ctl = '0;
  logic [15:0] last_word = 16'h0002;

  always #2.5 clk = ~clk;

  alu_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .operand_a(operand_a), .operand_b(operand_b),
    .alu_result(alu_result), .carry_in(carry_in), .op_class(op_class),
    .size_wide(size_wide), .flag_we(flag_we), .ctrl_we(ctrl_we),
    .ctrl_wdata(ctrl_wdata), .flags_out(flags_out)
  );

  function automatic logic [15:0] model(input logic [15:0] a, b, r, input logic c,
                                        input logic [1:0] k, input logic wd, input logic [2:0] ctl);
    int w, am, bm, rm, mask, cy, ax, zf, sf, pf, of, sa, sb;
    logic [15:0] f;
    w = wd ? 16 : 8;
    mask = (1 << w) - 1;
    am = int'(a) & mask; bm = int'(b) & mask; rm = int'(r) & mask;
    sa = (am >> (w-1)) & 1; sb = (bm >> (w-1)) & 1; sf = (rm >> (w-1)) & 1;
    zf = (rm == 0) ? 1 : 0;
    pf = 1;
    for (int i = 0; i < 8; i++) if (r[i]) pf = 1 - pf;
    cy = 0; ax = 0; of = 0;
    if (k == 2'b00) begin
      cy = ((am + bm + c) > mask) ? 1 : 0;
      ax = ((int'(a[3:0]) + int'(b[3:0]) + c) > 15) ? 1 : 0;
      of = (sa == sb && sf != sa) ? 1 : 0;
    end else if (k == 2'b01) begin
      cy = (am < bm + c) ? 1 : 0;
      ax = (int'(a[3:0]) < int'(b[3:0]) + c) ? 1 : 0;
      of = (sa != sb && sf != sa) ? 1 : 0;
    end
    f = 16'h0002;
    f[0] = cy[0]; f[2] = pf[0]; f[4] = ax[0]; f[6] = zf[0]; f[7] = sf[0]; f[11] = of[0];
    f[10:8] = ctl;
    return f;
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic alu_op(input string req, input logic [15:0] a, b, r, input logic c,
                        input logic [1:0] k, input logic wd);
    logic [15:0] exp;
    @(negedge clk);
    operand_a = a; operand_b = b; alu_result = r; carry_in = c;
    op_class = k; size_wide = wd; flag_we = 1'b1;
    exp = model(a, b, r, c, k, wd, shadow_ctl);
    @(posedge clk); #1;
    flag_we = 1'b0;
    check(req, flags_out, exp);
    last_word = exp;
  endtask

  task automatic test_reset();
    check("R1 reset", flags_out, 16'h0002);
    check("R10 reserved", flags_out & 16'hF02A, 16'h0002);
  endtask

  task automatic test_add();
    alu_op("R6 add8 overflow", 16'h007F, 16'h0001, 16'h0080, 1'b0, 2'b00, 1'b0);
    alu_op("R2 R5 add8 carry zero upper junk", 16'h00FF, 16'h0001, 16'h0100, 1'b0, 2'b00, 1'b0);
    alu_op("R2 R6 add16 carry overflow", 16'h8000, 16'h8000, 16'h0000, 1'b0, 2'b00, 1'b1);
    alu_op("R4 add16 half carry via cin", 16'h000F, 16'h0000, 16'h0010, 1'b1, 2'b00, 1'b1);
    alu_op("R5 add8 no ovf at bit15", 16'h7F10, 16'h7F20, 16'hFE30, 1'b0, 2'b00, 1'b0);
  endtask

  task automatic test_sub();
    alu_op("R2 R4 sub16 borrow", 16'h0000, 16'h0001, 16'hFFFF, 1'b0, 2'b01, 1'b1);
    alu_op("R6 sub8 overflow", 16'h0080, 16'h0001, 16'h007F, 1'b0, 2'b01, 1'b0);
    alu_op("R2 sub16 borrow-in equal", 16'h1234, 16'h1234, 16'hFFFF, 1'b1, 2'b01, 1'b1);
    alu_op("R6 sub16 overflow", 16'h7FFF, 16'hFFFF, 16'h8000, 1'b0, 2'b01, 1'b1);
    alu_op("R3 parity low byte", 16'h5A00, 16'h0000, 16'h5A03, 1'b0, 2'b01, 1'b1);
  endtask

  task automatic test_logic();
    alu_op("R7 logic 10", 16'h7FFF, 16'h7FFF, 16'h8000, 1'b1, 2'b10, 1'b1);
    check("R7 no cf af of", flags_out & 16'h0811, 16'h0000);
    alu_op("R7 logic 11", 16'h00FF, 16'h00FF, 16'h0000, 1'b1, 2'b11, 1'b0);
  endtask

  task automatic test_hold();
    @(negedge clk);
    operand_a = 16'hFFFF; operand_b = 16'h0001; alu_result = 16'h0000;
    carry_in = 1'b1; op_class = 2'b01; size_wide = 1'b1; flag_we = 1'b0;
    @(posedge clk); #1;
    check("R8 hold no we", flags_out, last_word);
    @(posedge clk); #1;
    check("R8 hold second cycle", flags_out, last_word);
  endtask

  task automatic test_ctrl();
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = 3'b101;
    @(posedge clk); #1;
    ctrl_we = 1'b0;
    shadow_ctl = 3'b101;
    last_word[10:8] = shadow_ctl;
    check("R9 ctrl load keeps status", flags_out, last_word);
    alu_op("R9 alu write keeps ctrl", 16'h0001, 16'h0001, 16'h0002, 1'b0, 2'b00, 1'b0);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = 3'b010;
    @(posedge clk); #1;
    ctrl_we = 1'b0;
    shadow_ctl = 3'b010;
    last_word[10:8] = shadow_ctl;
    check("R9 ctrl reload", flags_out, last_word);
    check("R10 reserved after writes", flags_out & 16'hF02A, 16'h0002);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 test_reset();
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", flags_out, 16'h0002);
    test_add();
    test_sub();
    test_logic();
    test_hold();
    test_ctrl();
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule